// File: doc/BRIEF.md
# Validation Event Scheduling Counters

This block lets validation software plant synthetic events inside a processor: a reset, an interrupt, a fast interrupt and an external debug request. Each event has its own up-counter. Software writes a start value into the counter, then starts it through an operation register. The counter advances once per clock while it runs. When it wraps from all ones to zero, it raises a one-cycle pulse on its event output. The core treats that pulse the same way as an event arriving from outside. After the wrap the counter halts, so every start produces at most one event.

The three main counters are 32 bits wide and the debug-request counter is 6 bits wide. To place an event N cycles after the start write, load 2^W − N, where W is the counter width. A single write to the operation register can start, stop or clear any subset of the four counters.

Clearing a counter ends its scheduling role and returns it to the monitor function. That function is represented here only by a per-counter mode flag. Register access is limited to secure privileged requests. A grant bit can open access to user-mode and non-secure requests, and only a secure privileged request may change that grant bit.

Top module: `evt_sched_top`

## Requirements
- R1: After reset all four counts read 0, the status and control registers read 0, and all event outputs and `access_err` are low.
- R2: A permitted write to address 0 (reset), 1 (interrupt), 2 (fast interrupt) or 3 (debug) loads that counter, and a read of the same address returns the count. The debug counter keeps only wdata[5:0], and its upper read bits are 0.
- R3: While a counter runs it gains 1 on every clock; after it is stopped its value holds. The start or stop write's own edge is the first edge on which the new state applies.
- R4: If a counter is loaded with 2^W − N and started, its event output is high for exactly one cycle, N cycles after the start write's clock edge, and the counter then reads 0.
- R5: After it fires, a counter stops itself, stays at 0, and gives no further event until it is started again.
- R6: A write to the operation register (address 4) starts each counter whose bit is set in wdata[3:0]: bit 0 reset, bit 1 interrupt, bit 2 fast interrupt, bit 3 debug. It also sets that counter's scheduling-mode flag.
- R7: Bits wdata[7:4] of an operation write stop the counters in the same bit order (4 reset, 5 interrupt, 6 fast interrupt, 7 debug).
- R8: If one operation write both starts and stops the same counter, that counter ends up stopped.
- R9: Bits wdata[11:8] of an operation write clear the counters in the same order: the counter stops and its scheduling-mode flag returns to 0 (monitor function).
- R10: A read of address 5 returns the running flags in bits [3:0] and the scheduling-mode flags in bits [7:4], each in the same counter order.
- R11: An access is permitted when `acc_secure` and `acc_priv` are both high, or when the grant bit (address 6, bit 0) is set. The grant register itself is permitted only to secure privileged requests.
- R12: A request that is not permitted changes no state and reads 0. On the following cycle `access_err` is high for one cycle.
- R13: The operation register is write-only and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| acc_secure | input | 1 | Request comes from the secure state |
| acc_priv | input | 1 | Request comes from a privileged mode |
| access_err | output | 1 | One-cycle flag for a refused request |
| evt_reset | output | 1 | Scheduled reset pulse |
| evt_irq | output | 1 | Scheduled interrupt pulse |
| evt_fiq | output | 1 | Scheduled fast-interrupt pulse |
| evt_dbg | output | 1 | Scheduled debug-request pulse |

## Verification
Read data is combinational, so the bench samples `rdata` 1 ns after the falling edge on which it placed the read. Loads, operations and the grant bit take effect on the next rising edge. `access_err` can be seen at the falling edge after the refused request's rising edge.

An event is due on the Nth rising edge after the start write's edge. The bench therefore counts falling edges from that point and expects each output high on exactly falling edge N, and low on every other one. Count values read back are predicted in the same way: the value loaded, plus one for every rising edge the counter spent running.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;
  localparam int NUM_EVT = 4;
  localparam int OP_START_LSB = 0;
  localparam int OP_STOP_LSB  = 4;
  localparam int OP_CLR_LSB   = 8;

  typedef enum logic [2:0] {
    A_CNT_RST = 3'd0,
    A_CNT_IRQ = 3'd1,
    A_CNT_FIQ = 3'd2,
    A_CNT_DBG = 3'd3,
    A_OP      = 3'd4,
    A_STAT    = 3'd5,
    A_CTRL    = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/evt_sched_access.sv
module evt_sched_access
  import evt_sched_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter int NE = NUM_EVT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          acc_secure,
  input  logic          acc_priv,
  output logic [NE-1:0] ld_en,
  output logic [NE-1:0] start_v,
  output logic [NE-1:0] stop_v,
  output logic [NE-1:0] clr_v,
  output logic          rd_ok,
  output logic          grant,
  output logic          access_err
);
  logic sec_priv, is_ctrl, permit, wr_ok, op_hit;
  logic grant_q, grant_d, err_q, err_d;

  always_comb begin
    sec_priv = acc_secure & acc_priv;
    is_ctrl  = (addr == AW'(A_CTRL));
    permit   = is_ctrl ? sec_priv : (sec_priv | grant_q);
    wr_ok    = wr_en & permit;
    rd_ok    = rd_en & permit;
    op_hit   = wr_ok & (addr == AW'(A_OP));
    start_v  = op_hit ? wdata[OP_START_LSB +: NE] : '0;
    stop_v   = op_hit ? wdata[OP_STOP_LSB  +: NE] : '0;
    clr_v    = op_hit ? wdata[OP_CLR_LSB   +: NE] : '0;
    grant_d  = (wr_ok & is_ctrl) ? wdata[0] : grant_q;
    err_d    = (wr_en | rd_en) & ~permit;
  end

  for (genvar g = 0; g < NE; g++) begin : g_ld
    assign ld_en[g] = wr_ok & (addr == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      grant_q <= grant_d;
      err_q   <= err_d;
    end
  end

  assign grant      = grant_q;
  assign access_err = err_q;
endmodule

// File: rtl/evt_sched_ctr.sv
module evt_sched_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         start,
  input  logic         stop,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         running,
  output logic         sched,
  output logic         fire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic run_q, run_d, sched_q, sched_d, fire_q, fire_d, wrap;

  always_comb begin
    wrap  = run_q & (&cnt_q) & ~ld_en;
    cnt_d = cnt_q;
    if (ld_en)      cnt_d = ld_val;
    else if (run_q) cnt_d = cnt_q + 1'b1;

    run_d = run_q;
    if (stop | clr)  run_d = 1'b0;
    else if (start)  run_d = 1'b1;
    else if (wrap)   run_d = 1'b0;

    sched_d = sched_q;
    if (clr)                 sched_d = 1'b0;
    else if (start & ~stop)  sched_d = 1'b1;

    fire_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      sched_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      run_q   <= run_d;
      sched_q <= sched_d;
      fire_q  <= fire_d;
    end
  end

  assign cnt     = cnt_q;
  assign running = run_q;
  assign sched   = sched_q;
  assign fire    = fire_q;
endmodule

// File: rtl/evt_sched_top.sv
module evt_sched_top
  import evt_sched_pkg::*;
#(
  parameter int MAIN_W = 32,
  parameter int DBG_W  = 6,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [MAIN_W-1:0] wdata,
  output logic [MAIN_W-1:0] rdata,
  input  logic              acc_secure,
  input  logic              acc_priv,
  output logic              access_err,
  output logic              evt_reset,
  output logic              evt_irq,
  output logic              evt_fiq,
  output logic              evt_dbg
);
  localparam int NE = NUM_EVT;

  logic [NE-1:0] ld_en, start_v, stop_v, clr_v, run_v, sched_v, fire_v;
  logic          rd_ok, grant;
  logic [MAIN_W-1:0] cnt_ext [NE];

  evt_sched_access #(.DW(MAIN_W), .AW(AW), .NE(NE)) u_acc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .acc_secure(acc_secure), .acc_priv(acc_priv),
    .ld_en(ld_en), .start_v(start_v), .stop_v(stop_v), .clr_v(clr_v),
    .rd_ok(rd_ok), .grant(grant), .access_err(access_err)
  );

  for (genvar g = 0; g < NE; g++) begin : g_ctr
    localparam int CW = (g == NE - 1) ? DBG_W : MAIN_W;
    logic [CW-1:0] c;
    evt_sched_ctr #(.W(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en[g]), .ld_val(wdata[CW-1:0]),
      .start(start_v[g]), .stop(stop_v[g]), .clr(clr_v[g]),
      .cnt(c), .running(run_v[g]), .sched(sched_v[g]), .fire(fire_v[g])
    );
    assign cnt_ext[g] = MAIN_W'(c);
  end

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      case (addr)
        AW'(A_CNT_RST): rdata = cnt_ext[0];
        AW'(A_CNT_IRQ): rdata = cnt_ext[1];
        AW'(A_CNT_FIQ): rdata = cnt_ext[2];
        AW'(A_CNT_DBG): rdata = cnt_ext[3];
        AW'(A_STAT): begin
          rdata[NE-1:0]    = run_v;
          rdata[2*NE-1:NE] = sched_v;
        end
        AW'(A_CTRL): rdata[0] = grant;
        default: rdata = '0;
      endcase
    end
  end

  assign evt_reset = fire_v[0];
  assign evt_irq   = fire_v[1];
  assign evt_fiq   = fire_v[2];
  assign evt_dbg   = fire_v[3];
endmodule

// File: rtl/evt_sched_chk.sv
module evt_sched_chk #(
  parameter int NE = 4,
  parameter int AW = 3,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          acc_secure,
  input logic          acc_priv,
  input logic          access_err,
  input logic          grant,
  input logic [NE-1:0] evt_vec,
  input logic [NE-1:0] run_vec
);
  logic sp;
  assign sp = acc_secure & acc_priv;

  for (genvar i = 0; i < NE; i++) begin : g_chk
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vec[i] |=> !evt_vec[i]); // R4
    AST_HALT_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vec[i] |-> !run_vec[i]); // R5
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(4) && (sp || grant) && wdata[i] && wdata[4+i]) |=> !run_vec[i]); // R8
    AST_CLR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(4) && (sp || grant) && wdata[8+i]) |=> !run_vec[i]); // R9
  end

  AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != AW'(6) && !sp && !grant) |=> access_err); // R12
  AST_CTRL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(6) && !sp) |=> $stable(grant)); // R11
endmodule

bind evt_sched_top evt_sched_chk #(.NE(4), .AW(AW), .DW(MAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .acc_secure(acc_secure), .acc_priv(acc_priv), .access_err(access_err),
  .grant(grant), .evt_vec({evt_dbg, evt_fiq, evt_irq, evt_reset}), .run_vec(run_v)
);

// File: tb/evt_sched_top_tb_top.sv
module evt_sched_top_tb_top;
  logic clk, rst_n, wr_en, rd_en, acc_secure, acc_priv;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic access_err, evt_reset, evt_irq, evt_fiq, evt_dbg;
  logic [3:0] evv;
  int n_chk, n_err;
  int nexp[4];
  logic [31:0] v;
  bit done;

  assign evv = {evt_dbg, evt_fiq, evt_irq, evt_reset};

  evt_sched_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .acc_secure(acc_secure), .acc_priv(acc_priv),
    .access_err(access_err), .evt_reset(evt_reset), .evt_irq(evt_irq),
    .evt_fiq(evt_fiq), .evt_dbg(evt_dbg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] q);
    rd_en = 1'b1; addr = a;
    #1 q = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] load_for(input int idx, input int n);
    if (idx == 3) return 32'((64 - n) % 64);
    return 32'd0 - 32'(n);
  endfunction

  task automatic sched_test(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) wr(3'(i), load_for(i, nexp[i]));
    wr(3'd4, {28'd0, m});
    for (int k = 1; k <= 70; k++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++)
        chk($sformatf("R4 evt%0d cycle %0d", i, k), {31'd0, evv[i]},
            {31'd0, (m[i] && k == nexp[i])});
    end
    for (int i = 0; i < 4; i++) if (m[i]) begin
      rd(3'(i), v); chk("R5 count stays 0 after event", v, 32'd0);
    end
    rd(3'd5, v); chk("R5 all stopped after events", v & 32'hF, 32'd0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    acc_secure = 1'b1; acc_priv = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin rd(3'(i), v); chk("R1 count reset", v, 32'd0); end
    rd(3'd5, v); chk("R1 status reset", v, 32'd0);
    rd(3'd6, v); chk("R1 ctrl reset", v, 32'd0);
    chk("R1 events low", {28'd0, evv}, 32'd0);
    chk("R1 err low", {31'd0, access_err}, 32'd0);

    // R2 load and readback
    wr(3'd1, 32'hDEADBEEF); rd(3'd1, v); chk("R2 irq load", v, 32'hDEADBEEF);
    wr(3'd3, 32'hFFFFFFFF); rd(3'd3, v); chk("R2 dbg 6-bit", v, 32'h3F);
    wr(3'd3, 32'd0);
    // R13 op register reads zero
    rd(3'd4, v); chk("R13 op reads 0", v, 32'd0);

    // R3 counting and holding
    wr(3'd0, 32'd100);
    wr(3'd4, 32'h1);
    rd(3'd0, v); chk("R3 first count", v, 32'd100);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R3 counts each clock", v, 32'd104);
    wr(3'd4, 32'h10);
    rd(3'd0, v); chk("R3 value after stop", v, 32'd106);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R3 holds when stopped", v, 32'd106);
    rd(3'd5, v); chk("R7 stop clears run bit", v, 32'h10);

    // R8 start and stop together
    wr(3'd4, 32'h22);
    rd(3'd5, v); chk("R8 stop wins", v, 32'h10);
    rd(3'd1, v); chk("R8 irq count held", v, 32'hDEADBEEF);

    // R6 / R10 start sets run and mode
    wr(3'd4, 32'h4);
    rd(3'd5, v); chk("R6 fiq running and mode", v, 32'h54);
    // R9 clear
    wr(3'd4, 32'h500);
    rd(3'd5, v); chk("R9 clear stops and resets mode", v, 32'h0);
    // R7 debug start/stop own bits
    wr(3'd4, 32'h8);
    rd(3'd5, v); chk("R6 dbg start", v, 32'h88);
    wr(3'd4, 32'h80);
    rd(3'd5, v); chk("R7 dbg stop", v, 32'h80);
    wr(3'd4, 32'hF00);
    rd(3'd5, v); chk("R9 clear all", v, 32'h0);

    // R11 / R12 permission
    acc_secure = 1'b0;
    wr(3'd0, 32'd5); chk("R12 denied write flags", {31'd0, access_err}, 32'd1);
    rd(3'd0, v); chk("R12 denied read is 0", v, 32'd0);
    chk("R12 denied read flags", {31'd0, access_err}, 32'd1);
    acc_secure = 1'b1;
    rd(3'd0, v); chk("R12 denied write ignored", v, 32'd106);
    chk("R12 flag clears", {31'd0, access_err}, 32'd0);
    acc_priv = 1'b0;
    wr(3'd0, 32'd9); chk("R11 secure user denied", {31'd0, access_err}, 32'd1);
    acc_priv = 1'b1;
    wr(3'd6, 32'd1);
    acc_secure = 1'b0; acc_priv = 1'b0;
    wr(3'd0, 32'd7); chk("R11 granted no err", {31'd0, access_err}, 32'd0);
    rd(3'd0, v); chk("R11 granted write took", v, 32'd7);
    wr(3'd6, 32'd0); chk("R11 ctrl guarded", {31'd0, access_err}, 32'd1);
    acc_secure = 1'b1; acc_priv = 1'b1;
    rd(3'd6, v); chk("R11 grant kept", v, 32'd1);
    wr(3'd6, 32'd0);

    // R4 / R5 directed corners
    nexp[0] = 1; nexp[1] = 2; nexp[2] = 3; nexp[3] = 64;
    sched_test(4'hF);
    nexp[0] = 40; nexp[1] = 40; nexp[2] = 5; nexp[3] = 1;
    sched_test(4'b1011);

    // constrained random schedules
    for (int t = 0; t < 20; t++) begin
      logic [3:0] m;
      m = 4'($urandom_range(1, 15));
      for (int i = 0; i < 3; i++) nexp[i] = int'($urandom_range(1, 60));
      nexp[3] = int'($urandom_range(1, 64));
      sched_test(m);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule